// File: doc/BRIEF.md
# Multi-Event Ring Capture Buffer with Time Stamps

The block records a continuous stream of digitised samples into a set of equal-sized ring buffers. One buffer is live at any time. Each sample slot writes one word at the live buffer's write pointer, and the pointer wraps, so the live buffer always holds the most recent window of the waveform. A trigger can come from the local self-trigger line or from the external trigger line, and each source has its own enable. When a trigger arrives, the block latches the free-running sample-slot time counter. It keeps writing for a programmable number of further samples and then freezes the buffer. The frozen buffer's index, its time stamp and the position of its oldest word go into an event queue, and recording moves to the next free buffer.

A host drains events in arrival order through a simple read strobe. Each strobe returns one word, oldest first. The strobe that reads the last word of a buffer returns that buffer to the free pool and removes the event from the queue. If every buffer is frozen, recording stops and each further trigger is counted as dropped.

The writer FSM has three states. ARM records and waits for a trigger. POST records the post-trigger samples. HOLD is entered when no buffer is free and does not record. Its transitions are:
- ARM→POST on a trigger with a non-zero post length.
- ARM→ARM (next buffer) or ARM→HOLD on a trigger with a zero post length.
- POST→ARM (next buffer) or POST→HOLD on the last post sample.
- HOLD→ARM once a buffer is released.

The reader FSM has two states. IDLE means the next read returns the first word of the head event. BODY means an event is part-way read. IDLE→BODY on the first read, and BODY→IDLE on the read of the last word.

Top module: `evt_ring_capture`

## Requirements
- R1: After reset, `evt_valid` is 0, `rd_vld` is 0 and `drop_cnt` is 0.
- R2: A TS_W-bit time counter starts at 0 and advances by one in every cycle with `smp_valid` high, wrapping modulo 2^TS_W. An event's stamp is the counter value in its trigger slot, which equals the number of earlier sample slots modulo 2^TS_W.
- R3: A trigger is taken only in a cycle where `smp_valid` is high and either (`self_trig` and `self_en`) or (`ext_trig` and `ext_en`) holds. A trigger line pulsed while its enable is low, or in a cycle without `smp_valid`, creates no event and does not change `drop_cnt`.
- R4: The trigger slot's sample is written, then exactly `post_len` further samples are written, then the buffer freezes. Reading the event returns DEPTH words, oldest first, ending with the last written sample.
- R5: With `post_len` = 0 the buffer freezes on the trigger slot itself, so the last word read is the trigger sample.
- R6: A trigger during the post-trigger window is ignored. It neither adds an event nor extends the window.
- R7: Events are presented in freeze order. While `evt_valid` is 1, `evt_buf` and `evt_stamp` describe the oldest unread event.
- R8: After a freeze, recording continues in the first free buffer found by counting up from the frozen index modulo NBUF. After reset, recording starts in buffer 0.
- R9: While no buffer is free, nothing is recorded, and each taken trigger increments `drop_cnt` by one (saturating) without creating an event.
- R10: The read of an event's last word removes the event and frees its buffer. A held writer then resumes recording in that buffer.
- R11: `rd_en` while `evt_valid` is 0 has no effect: `rd_vld` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample slot strobe |
| smp_data | input | DW | Sample value |
| self_trig | input | 1 | Local self-trigger line |
| ext_trig | input | 1 | External trigger line |
| self_en | input | 1 | Enable for the self-trigger line |
| ext_en | input | 1 | Enable for the external trigger line |
| post_len | input | PW | Number of samples written after the trigger sample |
| rd_en | input | 1 | Host read strobe, one word per cycle |
| rd_vld | output | 1 | `rd_data` holds a word read in the previous cycle |
| rd_data | output | DW | Word read from the head event |
| evt_valid | output | 1 | At least one frozen event is queued |
| evt_buf | output | BW | Buffer index of the head event |
| evt_stamp | output | TS_W | Time stamp of the head event |
| drop_cnt | output | CW | Number of triggers dropped while all buffers were full |

## Verification
A writer that selects the wrong next buffer shows up at `evt_buf` as soon as the following event reaches the queue head. A misplaced write pointer or read start shows up in the first word read, as a value that is not the expected sample index. A wrong post-trigger count or a lost trigger stamp shows up in the head event's `evt_stamp`, or in the last word of the same readout. A busy mask that never clears keeps the writer in HOLD, so the next trigger increments `drop_cnt` instead of producing an event.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;
    typedef enum logic [1:0] {W_ARM, W_POST, W_HOLD} wr_state_t;
    typedef enum logic       {R_IDLE, R_BODY}        rd_state_t;
endpackage

// File: rtl/capbuf_mem.sv
module capbuf_mem #(
    parameter int AW_T = 6,
    parameter int DW   = 10
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW_T-1:0] waddr,
    input  logic [DW-1:0]   wdata,
    input  logic            re,
    input  logic [AW_T-1:0] raddr,
    output logic [DW-1:0]   rdata
);
    localparam int NW = 1 << AW_T;

    logic [DW-1:0] store [NW];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
        if (re) rdata <= store[raddr];
    end
endmodule

// File: rtl/capbuf_fifo.sv
module capbuf_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int PTW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]   slots [DEPTH];
    logic [PTW-1:0] rp, wp;
    logic [PTW:0]   count;
    logic           full;

    assign empty = (count == '0);
    assign full  = (count == (PTW+1)'(DEPTH));
    assign dout  = slots[rp];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp    <= '0;
            wp    <= '0;
            count <= '0;
        end else begin
            if (push) begin
                slots[wp] <= din;
                wp        <= (wp == PTW'(DEPTH-1)) ? '0 : wp + 1'b1;
            end
            if (pop) rp <= (rp == PTW'(DEPTH-1)) ? '0 : rp + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    // R7
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));

    // R10
    fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/capbuf_writer.sv
module capbuf_writer
    import capbuf_pkg::*;
#(
    parameter int NBUF  = 4,
    parameter int DEPTH = 16,
    parameter int DW    = 10,
    parameter int TS_W  = 28,
    parameter int PW    = 5,
    parameter int CW    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic [DW-1:0]        smp_data,
    input  logic                 trig_src,
    input  logic [PW-1:0]        post_len,
    input  logic                 rel_en,
    input  logic [$clog2(NBUF)-1:0] rel_buf,
    output logic                 mem_we,
    output logic [$clog2(NBUF)+$clog2(DEPTH)-1:0] mem_waddr,
    output logic [DW-1:0]        mem_wdata,
    output logic                 push,
    output logic [$clog2(NBUF)-1:0]  push_buf,
    output logic [$clog2(DEPTH)-1:0] push_start,
    output logic [TS_W-1:0]      push_stamp,
    output logic [CW-1:0]        drop_cnt
);
    localparam int BW = $clog2(NBUF);
    localparam int AW = $clog2(DEPTH);

    wr_state_t      st, st_n;
    logic [BW-1:0]  cur, cur_n, pick;
    logic [AW-1:0]  wp, wp_n;
    logic [PW-1:0]  remain, remain_n;
    logic [NBUF-1:0] busy, busy_n, avail;
    logic [TS_W-1:0] tnow, stamp_q, stamp_n;
    logic [CW-1:0]  drops, drops_n;
    logic           hit, freeze, found;

    assign hit       = smp_valid & trig_src;
    assign mem_waddr = {cur, wp};
    assign mem_wdata = smp_data;
    assign drop_cnt  = drops;

    // rotating search for the next free buffer, starting after cur
    always_comb begin
        avail = ~busy;
        if (st != W_HOLD) avail[cur] = 1'b0;
        found = 1'b0;
        pick  = cur;
        for (int i = 1; i <= NBUF; i++) begin
            if (!found && avail[(int'(cur) + i) % NBUF]) begin
                found = 1'b1;
                pick  = BW'((int'(cur) + i) % NBUF);
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= W_ARM;
            cur     <= '0;
            wp      <= '0;
            remain  <= '0;
            busy    <= '0;
            stamp_q <= '0;
            drops   <= '0;
            tnow    <= '0;
        end else begin
            st      <= st_n;
            cur     <= cur_n;
            wp      <= wp_n;
            remain  <= remain_n;
            busy    <= busy_n;
            stamp_q <= stamp_n;
            drops   <= drops_n;
            if (smp_valid) tnow <= tnow + 1'b1;
        end
    end

    // next state and outputs
    always_comb begin
        st_n     = st;
        cur_n    = cur;
        wp_n     = wp;
        remain_n = remain;
        stamp_n  = stamp_q;
        drops_n  = drops;
        busy_n   = busy;
        mem_we   = 1'b0;
        freeze   = 1'b0;
        if (rel_en) busy_n[rel_buf] = 1'b0;
        unique case (st)
            W_ARM: begin
                if (smp_valid) begin
                    mem_we = 1'b1;
                    wp_n   = wp + 1'b1;
                    if (hit) begin
                        stamp_n = tnow;
                        if (post_len == '0) begin
                            freeze = 1'b1;
                        end else begin
                            remain_n = post_len;
                            st_n     = W_POST;
                        end
                    end
                end
            end
            W_POST: begin
                if (smp_valid) begin
                    mem_we   = 1'b1;
                    wp_n     = wp + 1'b1;
                    remain_n = remain - 1'b1;
                    if (remain == PW'(1)) freeze = 1'b1;
                end
            end
            W_HOLD: begin
                if (hit && drops != '1) drops_n = drops + 1'b1;
                if (found) begin
                    st_n  = W_ARM;
                    cur_n = pick;
                    wp_n  = '0;
                end
            end
            default: ;
        endcase
        if (freeze) begin
            busy_n[cur] = 1'b1;
            if (found) begin
                st_n  = W_ARM;
                cur_n = pick;
                wp_n  = '0;
            end else begin
                st_n = W_HOLD;
            end
        end
        push       = freeze;
        push_buf   = cur;
        push_start = wp + 1'b1;
        push_stamp = (st == W_ARM) ? tnow : stamp_q;
    end

    // R2
    time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> (tnow == TS_W'($past(tnow) + 1'b1)));

    // R8
    rec_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !busy[cur]);

    // R9
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != W_HOLD) |=> (drops == $past(drops)));

    // R9
    hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == W_HOLD) |-> !mem_we);
endmodule

// File: rtl/capbuf_reader.sv
module capbuf_reader
    import capbuf_pkg::*;
#(
    parameter int NBUF  = 4,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en,
    input  logic                     empty,
    input  logic [$clog2(NBUF)-1:0]  head_buf,
    input  logic [$clog2(DEPTH)-1:0] head_start,
    output logic                     mem_re,
    output logic [$clog2(NBUF)+$clog2(DEPTH)-1:0] mem_raddr,
    output logic                     rd_vld,
    output logic                     pop,
    output logic                     rel_en,
    output logic [$clog2(NBUF)-1:0]  rel_buf
);
    localparam int AW = $clog2(DEPTH);

    rd_state_t     st, st_n;
    logic [AW-1:0] wcnt, wcnt_n;
    logic          accept, last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= R_IDLE;
            wcnt   <= '0;
            rd_vld <= 1'b0;
        end else begin
            st     <= st_n;
            wcnt   <= wcnt_n;
            rd_vld <= accept;
        end
    end

    always_comb begin
        accept    = rd_en & ~empty;
        last      = (wcnt == AW'(DEPTH - 1));
        mem_re    = accept;
        mem_raddr = {head_buf, head_start + wcnt};
        pop       = accept & last;
        rel_en    = accept & last;
        rel_buf   = head_buf;
        st_n      = st;
        wcnt_n    = wcnt;
        unique case (st)
            R_IDLE: begin
                if (accept && !last) begin
                    st_n   = R_BODY;
                    wcnt_n = wcnt + 1'b1;
                end
            end
            R_BODY: begin
                if (accept) begin
                    if (last) begin
                        st_n   = R_IDLE;
                        wcnt_n = '0;
                    end else begin
                        wcnt_n = wcnt + 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    // R10
    body_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == R_BODY) |-> !empty);

    // R11
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty) |=> !rd_vld);
endmodule

// File: rtl/evt_ring_capture.sv
module evt_ring_capture #(
    parameter int NBUF  = 4,
    parameter int DEPTH = 16,
    parameter int DW    = 10,
    parameter int TS_W  = 28,
    parameter int PW    = 5,
    parameter int CW    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic [DW-1:0]           smp_data,
    input  logic                    self_trig,
    input  logic                    ext_trig,
    input  logic                    self_en,
    input  logic                    ext_en,
    input  logic [PW-1:0]           post_len,
    input  logic                    rd_en,
    output logic                    rd_vld,
    output logic [DW-1:0]           rd_data,
    output logic                    evt_valid,
    output logic [$clog2(NBUF)-1:0] evt_buf,
    output logic [TS_W-1:0]         evt_stamp,
    output logic [CW-1:0]           drop_cnt
);
    localparam int BW = $clog2(NBUF);
    localparam int AW = $clog2(DEPTH);
    localparam int EW = BW + AW + TS_W;

    logic            trig_src;
    logic            mem_we, mem_re;
    logic [BW+AW-1:0] mem_waddr, mem_raddr;
    logic [DW-1:0]   mem_wdata;
    logic            push, pop, empty, rel_en;
    logic [BW-1:0]   push_buf, rel_buf;
    logic [AW-1:0]   push_start, head_start;
    logic [TS_W-1:0] push_stamp;
    logic [EW-1:0]   head;

    assign trig_src = (self_trig & self_en) | (ext_trig & ext_en);

    capbuf_writer #(.NBUF(NBUF), .DEPTH(DEPTH), .DW(DW), .TS_W(TS_W),
                    .PW(PW), .CW(CW)) u_writer (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .trig_src(trig_src), .post_len(post_len),
        .rel_en(rel_en), .rel_buf(rel_buf),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .push(push), .push_buf(push_buf), .push_start(push_start),
        .push_stamp(push_stamp), .drop_cnt(drop_cnt)
    );

    capbuf_fifo #(.W(EW), .DEPTH(NBUF)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push),
        .din({push_buf, push_start, push_stamp}),
        .pop(pop), .dout(head), .empty(empty)
    );

    assign evt_valid  = ~empty;
    assign evt_buf    = head[EW-1 -: BW];
    assign head_start = head[TS_W +: AW];
    assign evt_stamp  = head[TS_W-1:0];

    capbuf_reader #(.NBUF(NBUF), .DEPTH(DEPTH)) u_reader (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .empty(empty),
        .head_buf(evt_buf), .head_start(head_start),
        .mem_re(mem_re), .mem_raddr(mem_raddr), .rd_vld(rd_vld),
        .pop(pop), .rel_en(rel_en), .rel_buf(rel_buf)
    );

    capbuf_mem #(.AW_T(BW + AW), .DW(DW)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .re(mem_re), .raddr(mem_raddr), .rdata(rd_data)
    );

    // R9
    drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt == $past(drop_cnt)) || (drop_cnt == CW'($past(drop_cnt) + 1'b1)));
endmodule

// File: tb/test_evt_ring_capture.sv
module test_evt_ring_capture;
    localparam int NBUF = 4, DEPTH = 16, DW = 10, TS_W = 8, PW = 5, CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0, self_trig = 1'b0, ext_trig = 1'b0;
    logic self_en = 1'b0, ext_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic [PW-1:0] post_len = '0;
    logic rd_vld, evt_valid;
    logic [DW-1:0] rd_data;
    logic [1:0] evt_buf;
    logic [TS_W-1:0] evt_stamp;
    logic [CW-1:0] drop_cnt;

    int n = 0;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    evt_ring_capture #(.NBUF(NBUF), .DEPTH(DEPTH), .DW(DW), .TS_W(TS_W),
                       .PW(PW), .CW(CW)) i_evt_ring_capture (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .self_trig(self_trig), .ext_trig(ext_trig), .self_en(self_en),
        .ext_en(ext_en), .post_len(post_len), .rd_en(rd_en),
        .rd_vld(rd_vld), .rd_data(rd_data), .evt_valid(evt_valid),
        .evt_buf(evt_buf), .evt_stamp(evt_stamp), .drop_cnt(drop_cnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_slot(input logic st, input logic et);
        smp_valid = 1'b1; smp_data = DW'(n % 1024); self_trig = st; ext_trig = et;
        @(negedge clk);
        smp_valid = 1'b0; self_trig = 1'b0; ext_trig = 1'b0; n++;
        @(negedge clk);
    endtask

    task automatic run_slots(input int cnt);
        for (int i = 0; i < cnt; i++) do_slot(1'b0, 1'b0);
    endtask

    // reads one event; last = index of the final sample written
    task automatic read_event(input string req, input int ebuf, input int t, input int last);
        chk(evt_valid == 1'b1, req, int'(evt_valid), 1);
        chk(evt_buf == 2'(ebuf), req, int'(evt_buf), ebuf);
        chk(evt_stamp == TS_W'(t % 256), req, int'(evt_stamp), t % 256);
        rd_en = 1'b1;
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            if (k == DEPTH - 1) rd_en = 1'b0;
            chk(rd_vld && rd_data == DW'((last - DEPTH + 1 + k) % 1024), req,
                int'(rd_data), (last - DEPTH + 1 + k) % 1024);
        end
        @(negedge clk);
    endtask

    task automatic t_reset;
        // R1
        chk(evt_valid == 1'b0, "R1", int'(evt_valid), 0);
        chk(rd_vld == 1'b0, "R1", int'(rd_vld), 0);
        chk(drop_cnt == '0, "R1", int'(drop_cnt), 0);
    endtask

    task automatic t_basic;
        int t;
        self_en = 1'b1; ext_en = 1'b0; post_len = 5'd5;
        run_slots(20);
        t = n; do_slot(1'b1, 1'b0);
        run_slots(8);
        // R2 R4 R7 R8: first event in buffer 0, post window of 5
        read_event("R4", 0, t, t + 5);
        // R10: event removed after last word
        chk(evt_valid == 1'b0, "R10", int'(evt_valid), 0);
    endtask

    task automatic t_qualify;
        self_en = 1'b1; ext_en = 1'b0; post_len = 5'd0;
        do_slot(1'b0, 1'b1);
        self_trig = 1'b1; @(negedge clk); self_trig = 1'b0; @(negedge clk);
        run_slots(2);
        // R3
        chk(evt_valid == 1'b0, "R3", int'(evt_valid), 0);
        chk(drop_cnt == '0, "R3", int'(drop_cnt), 0);
        // R11
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        chk(rd_vld == 1'b0, "R11", int'(rd_vld), 0);
        @(negedge clk);
    endtask

    task automatic t_post_modes;
        int ta, tb;
        self_en = 1'b0; ext_en = 1'b1; post_len = 5'd0;
        run_slots(20);
        ta = n; do_slot(1'b0, 1'b1);
        post_len = 5'd3;
        run_slots(20);
        tb = n; do_slot(1'b0, 1'b1);
        do_slot(1'b0, 1'b1);
        run_slots(6);
        // R5: zero post length, R8: buffer 1 follows buffer 0
        read_event("R5", 1, ta, ta);
        // R6: retrigger ignored, window still 3; R7 order
        read_event("R6", 2, tb, tb + 3);
        chk(evt_valid == 1'b0, "R6", int'(evt_valid), 0);
    endtask

    task automatic t_overflow;
        int ts[4];
        int tn;
        self_en = 1'b1; ext_en = 1'b1; post_len = 5'd0;
        for (int i = 0; i < 4; i++) begin
            run_slots(40);
            ts[i] = n; do_slot(1'b0, 1'b1);
        end
        run_slots(2);
        do_slot(1'b0, 1'b1);
        run_slots(1);
        do_slot(1'b1, 1'b0);
        @(negedge clk);
        // R9
        chk(drop_cnt == 8'd2, "R9", int'(drop_cnt), 2);
        // R8: rotation 3,0,1,2
        read_event("R8", 3, ts[0], ts[0]);
        @(negedge clk); @(negedge clk);
        run_slots(20);
        tn = n; do_slot(1'b1, 1'b0);
        run_slots(2);
        read_event("R7", 0, ts[1], ts[1]);
        read_event("R7", 1, ts[2], ts[2]);
        read_event("R7", 2, ts[3], ts[3]);
        // R10: held writer resumed in released buffer 3
        read_event("R10", 3, tn, tn);
        chk(drop_cnt == 8'd2, "R9", int'(drop_cnt), 2);
        chk(evt_valid == 1'b0, "R10", int'(evt_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_qualify();
        t_post_modes();
        t_overflow();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule